// File: doc/BRIEF.md
# Nibble Load Unit with Repeated-Immediate Squashing

This block executes decoded load and store instructions on 4-bit data. There is one instruction per clock, qualified by `in_valid`. It holds eight 4-bit working registers and a 256 x 4-bit data memory. Register indices are A=0, E=1, L=2, H=3, X=4, W=5, Z=6 and Y=7. Pairs are formed as pair p = {reg 2p+1 (high), reg 2p (low)}. This gives EA (p=0), HL (p=1), WX (p=2) and YZ (p=3).

Some immediate loads belong to a group. These are a 4-bit immediate into A, an 8-bit immediate into EA, and an 8-bit immediate into HL. When loads of the same group arrive back to back, only the first one executes. The later ones retire as no-operations and pulse `squashed`.

A three-state run tracker records which group the last accepted instruction belonged to. Its states are RUN_IDLE (no group), RUN_AEA (A/EA group) and RUN_HL (HL group). Its transitions are:
- START: an executed grouped load moves the tracker into that group's state.
- SWITCH: a grouped load of the other group executes and moves the tracker into its own state.
- HOLD: a squashed load, or a cycle with `in_valid` low, keeps the state.
- BREAK: any non-grouped instruction returns the tracker to RUN_IDLE.
- Reset puts the tracker in RUN_IDLE.

Registers and any memory location can be observed through the observation port.

Top module: `ldsq_unit`

## Requirements
- R1: After reset, every register reads 0, every memory location reads 0, `squashed` is 0, and the first grouped load executes.
- R2: Op 6 loads `in_imm[3:0]` into the register selected by `in_sel`, using the index encoding A=0 through Y=7. Op 7 loads `in_imm` into the pair selected by `in_sel[1:0]` (0 EA, 1 HL, 2 WX, 3 YZ), with the high nibble going to the odd register.
- R3: Op 4 copies register `in_sel` into A. Op 5 copies A into register `in_sel`.
- R4: Op 2 loads A from memory at `in_addr`. Op 3 writes A to memory at `in_addr`, and the stored value is readable on the next cycle.
- R5: Op 0 loads A from memory, and op 1 stores A to memory, at the address held in a pair chosen by `in_sel[1:0]`: 0 HL, 1 WX, 2 {W,L}, 3 HL. The address is the pair value from before the cycle.
- R6: An immediate load into A (op 6, sel 0) and an immediate load into EA (op 7, sel 0) form one group. A load of this group that directly follows another load of the same group is squashed.
- R7: An immediate load into HL (op 7, sel 1) forms its own group. A second or later consecutive HL immediate load is squashed.
- R8: Any other accepted instruction ends the run, so the next grouped load executes. This includes immediate loads into E..Y and into WX or YZ. A grouped load that follows the other group also executes.
- R9: A squashed instruction changes no register and no memory location.
- R10: `squashed` is high for exactly the one cycle after each squashed instruction, and low otherwise.
- R11: Cycles with `in_valid` low change nothing and do not end a run.
- R12: The sequence A<-1, EA<-02h, A<-3, store A to 23h leaves 1 at 23h. The sequence HL<-10h, HL<-20h, A<-3, EA<-35h, store A to @HL writes 3 to address 10h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode 0..7 (see R2-R5) |
| in_sel | input | 3 | Register index, pair index, or indirect pair select |
| in_imm | input | 8 | Immediate data |
| in_addr | input | 8 | Direct memory address |
| obs_addr | input | 8 | Memory observation address |
| obs_mem | output | 4 | Memory content at `obs_addr` (combinational) |
| obs_regs | output | 32 | All registers; register i is at bits [4i+3:4i] |
| squashed | output | 1 | One-cycle pulse after a squashed instruction |

## Verification
The bench targets the cases where a run must survive and the cases where it must end. These are idle gaps between grouped loads, A and EA mixed within one run, and switching directly between the two groups. They also include breaking a run with a non-A immediate or a WX immediate. A tracker that reset on idle cycles would execute the second load after a gap. A tracker that treated all immediates as one group would squash the A load that follows an HL load. Either fault shows up in the register image or in the store results of the two worked sequences. Indirect accesses through all three address pairs check that the address is taken from the pair before the cycle's update. A wrong pair mapping writes to the wrong location.

// File: rtl/ldsq_pkg.sv
package ldsq_pkg;
    typedef enum logic [2:0] {
        OP_LD_A_IND   = 3'd0,
        OP_ST_A_IND   = 3'd1,
        OP_LD_A_DIR   = 3'd2,
        OP_ST_A_DIR   = 3'd3,
        OP_LD_A_REG   = 3'd4,
        OP_LD_REG_A   = 3'd5,
        OP_LD_REG_IMM = 3'd6,
        OP_LD_PAIR_IMM = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_AEA  = 2'd1,
        RUN_HL   = 2'd2
    } run_e;

    localparam logic [2:0] REG_A = 3'd0;
    localparam logic [2:0] REG_L = 3'd2;
    localparam logic [2:0] REG_H = 3'd3;
    localparam logic [2:0] REG_X = 3'd4;
    localparam logic [2:0] REG_W = 3'd5;

    localparam logic [1:0] PAIR_EA = 2'd0;
    localparam logic [1:0] PAIR_HL = 2'd1;
endpackage

// File: rtl/ldsq_classify.sv
module ldsq_classify
    import ldsq_pkg::*;
(
    input  logic [2:0] op,
    input  logic [2:0] sel,
    output run_e       grp
);
    always_comb begin
        grp = RUN_IDLE;
        if (op == OP_LD_REG_IMM && sel == REG_A) begin
            grp = RUN_AEA;
        end else if (op == OP_LD_PAIR_IMM && sel[1:0] == PAIR_EA) begin
            grp = RUN_AEA;
        end else if (op == OP_LD_PAIR_IMM && sel[1:0] == PAIR_HL) begin
            grp = RUN_HL;
        end
    end
endmodule

// File: rtl/ldsq_run_fsm.sv
module ldsq_run_fsm
    import ldsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  run_e grp_in,
    output logic squash_now,
    output logic squashed_q
);
    run_e state, state_nx;
    logic squash_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RUN_IDLE;
            squashed_q <= 1'b0;
        end else begin
            state      <= state_nx;
            squashed_q <= squash_c;
        end
    end

    always_comb begin
        state_nx = state;
        squash_c = 1'b0;
        if (in_valid) begin
            unique case (state)
                RUN_IDLE: begin
                    state_nx = grp_in;
                end
                RUN_AEA: begin
                    if (grp_in == RUN_AEA) squash_c = 1'b1;
                    state_nx = grp_in;
                end
                RUN_HL: begin
                    if (grp_in == RUN_HL) squash_c = 1'b1;
                    state_nx = grp_in;
                end
                default: state_nx = RUN_IDLE;
            endcase
        end
    end

    assign squash_now = squash_c;

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state));
    // R10
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squashed_q |-> $past(in_valid));
    // R6
    squash_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squashed_q |-> state != RUN_IDLE);
    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);
endmodule

// File: rtl/ldsq_regfile.sv
module ldsq_regfile #(
    parameter int DW   = 4,
    parameter int NREG = 8,
    localparam int NPAIR = NREG / 2,
    localparam int SW    = $clog2(NREG),
    localparam int PW    = $clog2(NPAIR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_single,
    input  logic [SW-1:0]        wsel,
    input  logic [DW-1:0]        wdata,
    input  logic                 we_pair,
    input  logic [PW-1:0]        psel,
    input  logic [2*DW-1:0]      pdata,
    output logic [NREG*DW-1:0]   regs_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int PI = i / 2;
        localparam int HI = i % 2;
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (we_single && wsel == SW'(i)) begin
                r <= wdata;
            end else if (we_pair && psel == PW'(PI)) begin
                r <= pdata[HI*DW +: DW];
            end
        end
        assign regs_flat[i*DW +: DW] = r;
    end

    // R9
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_single && we_pair));
    // R2
    pair_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_pair |=> regs_flat[{psel_q, 1'b0}*DW +: 2*DW] == pdata_q);

    logic [PW-1:0]   psel_q;
    logic [2*DW-1:0] pdata_q;
    always_ff @(posedge clk) begin
        psel_q  <= psel;
        pdata_q <= pdata;
    end
endmodule

// File: rtl/ldsq_dmem.sv
module ldsq_dmem #(
    parameter int DW = 4,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] oaddr,
    output logic [DW-1:0] odata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
    assign odata = mem[oaddr];

    // R4
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/ldsq_unit.sv
module ldsq_unit
    import ldsq_pkg::*;
#(
    parameter int DW   = 4,
    parameter int AW   = 2 * DW,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG),
    localparam int PW  = $clog2(NREG / 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         in_op,
    input  logic [2:0]         in_sel,
    input  logic [2*DW-1:0]    in_imm,
    input  logic [AW-1:0]      in_addr,
    input  logic [AW-1:0]      obs_addr,
    output logic [DW-1:0]      obs_mem,
    output logic [NREG*DW-1:0] obs_regs,
    output logic               squashed
);
    run_e          grp;
    logic          squash_now;
    logic          exec;
    logic [NREG*DW-1:0] regs_flat;
    logic [DW-1:0] reg_a, reg_l, reg_h, reg_x, reg_w;
    logic [AW-1:0] ind_addr;

    logic          we_single, we_pair, mem_we;
    logic [SW-1:0] wsel;
    logic [DW-1:0] wdata, mem_wdata, mem_rdata;
    logic [PW-1:0] psel;
    logic [AW-1:0] mem_waddr, mem_raddr;

    ldsq_classify u_cls (.op(in_op), .sel(in_sel), .grp(grp));

    ldsq_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .grp_in(grp),
        .squash_now(squash_now), .squashed_q(squashed)
    );

    assign reg_a = regs_flat[REG_A*DW +: DW];
    assign reg_l = regs_flat[REG_L*DW +: DW];
    assign reg_h = regs_flat[REG_H*DW +: DW];
    assign reg_x = regs_flat[REG_X*DW +: DW];
    assign reg_w = regs_flat[REG_W*DW +: DW];

    always_comb begin
        unique case (in_sel[1:0])
            2'd1:    ind_addr = AW'({reg_w, reg_x});
            2'd2:    ind_addr = AW'({reg_w, reg_l});
            default: ind_addr = AW'({reg_h, reg_l});
        endcase
    end

    assign exec = in_valid && !squash_now;

    always_comb begin
        we_single = 1'b0;
        wsel      = in_sel;
        wdata     = in_imm[DW-1:0];
        we_pair   = 1'b0;
        psel      = in_sel[PW-1:0];
        mem_we    = 1'b0;
        mem_waddr = in_addr;
        mem_wdata = reg_a;
        mem_raddr = in_addr;
        if (exec) begin
            unique case (op_e'(in_op))
                OP_LD_A_IND: begin
                    mem_raddr = ind_addr;
                    we_single = 1'b1;
                    wsel      = REG_A;
                    wdata     = mem_rdata;
                end
                OP_ST_A_IND: begin
                    mem_we    = 1'b1;
                    mem_waddr = ind_addr;
                end
                OP_LD_A_DIR: begin
                    we_single = 1'b1;
                    wsel      = REG_A;
                    wdata     = mem_rdata;
                end
                OP_ST_A_DIR: begin
                    mem_we = 1'b1;
                end
                OP_LD_A_REG: begin
                    we_single = 1'b1;
                    wsel      = REG_A;
                    wdata     = regs_flat[in_sel*DW +: DW];
                end
                OP_LD_REG_A: begin
                    we_single = 1'b1;
                    wdata     = reg_a;
                end
                OP_LD_REG_IMM: begin
                    we_single = 1'b1;
                end
                OP_LD_PAIR_IMM: begin
                    we_pair = 1'b1;
                end
                default: ;
            endcase
        end
    end

    ldsq_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we_single(we_single), .wsel(wsel), .wdata(wdata),
        .we_pair(we_pair), .psel(psel), .pdata(in_imm),
        .regs_flat(regs_flat)
    );

    ldsq_dmem #(.DW(DW), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata),
        .oaddr(obs_addr), .odata(obs_mem)
    );

    assign obs_regs = regs_flat;

    // R9
    squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && squash_now) |=> $stable(obs_regs));
    // R10
    squash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && squash_now) |=> squashed);
    // R11
    idle_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(obs_regs) && !squashed);
endmodule

// File: tb/sim_ldsq_unit.sv
module sim_ldsq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [2:0]  in_sel = '0;
    logic [7:0]  in_imm = '0;
    logic [7:0]  in_addr = '0;
    logic [7:0]  obs_addr = '0;
    logic [3:0]  obs_mem;
    logic [31:0] obs_regs;
    logic        squashed;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ldsq_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_sel(in_sel), .in_imm(in_imm), .in_addr(in_addr),
        .obs_addr(obs_addr), .obs_mem(obs_mem), .obs_regs(obs_regs),
        .squashed(squashed)
    );

    typedef struct {
        logic [31:0] regs;
        logic        sq;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [3:0] mreg [8];
    logic [3:0] mmem [256];
    int         mgrp = 0;

    function automatic logic [31:0] flat();
        logic [31:0] f;
        for (int i = 0; i < 8; i++) f[i*4 +: 4] = mreg[i];
        return f;
    endfunction

    task automatic send(input logic [2:0] op, input logic [2:0] sel,
                        input logic [7:0] imm, input logic [7:0] addr,
                        input string tag);
        int g;
        logic sq;
        logic [7:0] ia;
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_sel = sel; in_imm = imm; in_addr = addr;
        g = 0;
        if (op == 3'd6 && sel == 3'd0) g = 1;
        if (op == 3'd7 && sel[1:0] == 2'd0) g = 1;
        if (op == 3'd7 && sel[1:0] == 2'd1) g = 2;
        sq = (g != 0 && g == mgrp);
        mgrp = g;
        case (sel[1:0])
            2'd1: ia = {mreg[5], mreg[4]};
            2'd2: ia = {mreg[5], mreg[2]};
            default: ia = {mreg[3], mreg[2]};
        endcase
        if (!sq) begin
            case (op)
                3'd0: mreg[0] = mmem[ia];
                3'd1: mmem[ia] = mreg[0];
                3'd2: mreg[0] = mmem[addr];
                3'd3: mmem[addr] = mreg[0];
                3'd4: mreg[0] = mreg[sel];
                3'd5: mreg[sel] = mreg[0];
                3'd6: mreg[sel] = imm[3:0];
                default: begin
                    mreg[sel[1:0]*2]     = imm[3:0];
                    mreg[sel[1:0]*2 + 1] = imm[7:4];
                end
            endcase
        end
        e.regs = flat(); e.sq = sq; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        e.regs = flat(); e.sq = 1'b0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic mem_chk(input logic [7:0] a, input logic [3:0] expv, input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        obs_addr = a;
        #1;
        total++;
        if (obs_mem !== expv || mmem[a] !== expv) begin
            bad++;
            $display("FAIL %s mem[%02h] actual=%h expected=%h", tag, a, obs_mem, expv);
        end
    endtask

    // monitor: compares each queued expectation after the edge that applied it
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (obs_regs !== e.regs || squashed !== e.sq) begin
                bad++;
                $display("FAIL %s regs actual=%h expected=%h sq actual=%b expected=%b",
                         e.tag, obs_regs, e.regs, squashed, e.sq);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        for (int i = 0; i < 256; i++) mmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        total++;
        if (obs_regs !== 32'h0 || squashed !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset actual=%h/%b expected=0/0", obs_regs, squashed);
        end
        mem_chk(8'h00, 4'h0, "R1");
        mem_chk(8'hff, 4'h0, "R1");
        send(3'd6, 3'd0, 8'h09, 8'h00, "R1 first A imm executes");
        // R2 single-register immediates (non-grouped, each ends run)
        send(3'd6, 3'd1, 8'h01, 8'h00, "R2 E imm");
        send(3'd6, 3'd2, 8'h02, 8'h00, "R2 L imm");
        send(3'd6, 3'd3, 8'h03, 8'h00, "R2 H imm");
        send(3'd6, 3'd7, 8'h0e, 8'h00, "R2 Y imm");
        send(3'd7, 3'd2, 8'h5c, 8'h00, "R2 WX pair imm");
        send(3'd7, 3'd3, 8'ha6, 8'h00, "R2 YZ pair imm");
        // R3 register transfers
        send(3'd4, 3'd4, 8'h00, 8'h00, "R3 A<-X");
        send(3'd5, 3'd6, 8'h00, 8'h00, "R3 Z<-A");
        send(3'd4, 3'd3, 8'h00, 8'h00, "R3 A<-H");
        // R4 direct store and load
        send(3'd3, 3'd0, 8'h00, 8'h7b, "R4 store A direct");
        mem_chk(8'h7b, 4'h3, "R4");
        send(3'd6, 3'd0, 8'h0d, 8'h00, "R4 A imm");
        send(3'd2, 3'd0, 8'h00, 8'h7b, "R4 load A direct");
        // R5 indirect via HL, WX, WL, alias 3
        send(3'd1, 3'd0, 8'h00, 8'h00, "R5 store @HL");
        mem_chk(8'h32, 4'h3, "R5");
        send(3'd6, 3'd0, 8'h08, 8'h00, "R5 A imm");
        send(3'd1, 3'd1, 8'h00, 8'h00, "R5 store @WX");
        mem_chk(8'h5c, 4'h8, "R5");
        send(3'd6, 3'd0, 8'h04, 8'h00, "R5 A imm");
        send(3'd1, 3'd2, 8'h00, 8'h00, "R5 store @WL");
        mem_chk(8'h52, 4'h4, "R5");
        send(3'd0, 3'd1, 8'h00, 8'h00, "R5 load @WX");
        send(3'd0, 3'd3, 8'h00, 8'h00, "R5 load @HL via alias");
        // R6 A/EA group run with idle gap (R11)
        send(3'd6, 3'd0, 8'h05, 8'h00, "R6 A imm starts run");
        idle("R11 idle");
        idle("R11 idle");
        send(3'd6, 3'd0, 8'h06, 8'h00, "R11 A imm after idle squashed");
        send(3'd7, 3'd0, 8'hf1, 8'h00, "R6 EA imm squashed");
        send(3'd6, 3'd0, 8'h0a, 8'h00, "R9 A imm squashed no change");
        // R8 breakers
        send(3'd6, 3'd1, 8'h0c, 8'h00, "R8 E imm breaks run");
        send(3'd6, 3'd0, 8'h07, 8'h00, "R8 A imm after E executes");
        send(3'd7, 3'd2, 8'h3d, 8'h00, "R8 WX imm breaks run");
        send(3'd7, 3'd0, 8'h4b, 8'h00, "R8 EA imm after WX executes");
        send(3'd7, 3'd1, 8'h99, 8'h00, "R8 HL after EA executes");
        send(3'd7, 3'd1, 8'h88, 8'h00, "R7 HL again squashed");
        send(3'd7, 3'd1, 8'h77, 8'h00, "R7 HL third squashed");
        send(3'd6, 3'd0, 8'h02, 8'h00, "R8 A after HL executes");
        send(3'd3, 3'd0, 8'h00, 8'h40, "R8 store breaks");
        send(3'd6, 3'd0, 8'h01, 8'h00, "R8 A after store executes");
        send(3'd1, 3'd0, 8'h00, 8'h00, "R9 store @HL");
        mem_chk(8'h99, 4'h1, "R9");
        // R12 worked sequences
        send(3'd3, 3'd0, 8'h00, 8'h00, "R12 break");
        send(3'd6, 3'd0, 8'h01, 8'h00, "R12 A<-1");
        send(3'd7, 3'd0, 8'h02, 8'h00, "R12 EA<-02 squashed");
        send(3'd6, 3'd0, 8'h03, 8'h00, "R12 A<-3 squashed");
        send(3'd3, 3'd0, 8'h00, 8'h23, "R12 store 23h");
        mem_chk(8'h23, 4'h1, "R12 seq1");
        send(3'd7, 3'd1, 8'h10, 8'h00, "R12 HL<-10");
        send(3'd7, 3'd1, 8'h20, 8'h00, "R12 HL<-20 squashed");
        send(3'd6, 3'd0, 8'h03, 8'h00, "R12 A<-3 executes");
        send(3'd7, 3'd0, 8'h35, 8'h00, "R12 EA<-35 squashed");
        send(3'd1, 3'd0, 8'h00, 8'h00, "R12 store @HL");
        mem_chk(8'h10, 4'h3, "R12 seq2");
        mem_chk(8'h20, 4'h0, "R12 seq2 untouched");
        idle("R10 drain");
        idle("R10 drain");
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule